// File: doc/BRIEF.md
# Dual Halfword Multiply-Subtract Accumulator

This execute-stage datapath treats each of two 32-bit operands as a pair of signed 16-bit halfwords. It forms two signed 16x16 products and subtracts the product of the upper halfwords from the product of the lower halfwords. It then adds an accumulate value. The lower halfword of a word is bits 15:0 and the upper halfword is bits 31:16. An exchange control swaps the two halfwords of the second operand before the multiplies, which crosses the pairing.

In 32-bit mode the block adds a signed 32-bit accumulate word and returns a 32-bit wrapped result. A sticky saturation flag records any signed overflow of that addition. In long mode the block sign-extends the difference and adds it to a 64-bit accumulate value supplied as high and low words, and returns a 64-bit wrapped result. All results are registered, so they appear one clock after the valid strobe.

Top module: `dual_msub_acc`

## Requirements
- R1: With `xchg_b` low, the product pair is a[15:0]*b[15:0] and a[31:16]*b[31:16], all halfwords signed, and the difference is the lower product minus the upper product.
- R2: With `xchg_b` high, the products are a[15:0]*b[31:16] and a[31:16]*b[15:0], and the difference is the first minus the second.
- R3: In 32-bit mode (`long_sel` low), `res_lo` is the difference plus `acc_lo`, wrapped to 32 bits. `res_hi` is zero, and `acc_hi` has no effect.
- R4: The difference never saturates or overflows. For a=0x80008000 and b=0x7FFF8000 with a zero accumulator, the result is 2147450880 and the sticky flag stays clear.
- R5: In 32-bit mode, `q_flag` becomes 1 when the accumulate addition overflows as a signed 32-bit add, in either the positive or the negative direction. The wrapped sum is still delivered.
- R6: `q_flag` stays set until `q_clear` is high on a clock edge. If a clear and a new 32-bit overflow occur in the same cycle, the flag ends up set.
- R7: In long mode, {`res_hi`,`res_lo`} is the sign-extended difference plus {`acc_hi`,`acc_lo`}, wrapped to 64 bits, and this mode never sets `q_flag`.
- R8: `res_valid` and the result words are updated one clock after `in_valid` is sampled high. `res_valid` is low one clock after `in_valid` is sampled low.
- R9: While `in_valid` is low, `res_hi` and `res_lo` hold their values and `q_flag` changes only through `q_clear`.
- R10: Asserting `rst_n` low clears `res_valid`, `res_hi`, `res_lo` and `q_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| long_sel | input | 1 | 0: 32-bit mode, 1: 64-bit accumulate mode |
| xchg_b | input | 1 | Swap halfwords of operand b |
| op_a | input | 32 | First operand, two signed halfwords |
| op_b | input | 32 | Second operand, two signed halfwords |
| acc_hi | input | 32 | Upper accumulate word (long mode only) |
| acc_lo | input | 32 | Accumulate word / lower accumulate word |
| q_clear | input | 1 | Clears the sticky overflow flag |
| res_valid | output | 1 | Result strobe |
| res_hi | output | 32 | Upper result word (zero in 32-bit mode) |
| res_lo | output | 32 | Result word / lower result word |
| q_flag | output | 1 | Sticky accumulate-overflow flag |

## Verification
All three results are due on the first rising edge after the inputs are presented: `res_valid`, the result words and `q_flag`. The bench drives each operation on a falling edge and samples the outputs on the next falling edge, half a period after the registering edge. The bench keeps its own copy of the sticky flag and updates it once per edge from the same clear and overflow rules. Idle cycles are sampled the same way to confirm that the held results and the flag did not move.

// File: rtl/dmsa_pkg.sv
package dmsa_pkg;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned WORD_W = 2 * HALF_W;
  localparam int unsigned LANES  = 2;

  typedef struct packed {
    logic [WORD_W-1:0] hi;
    logic [WORD_W-1:0] lo;
  } dword_t;
endpackage

// File: rtl/dmsa_hmul.sv
module dmsa_hmul #(
  parameter int unsigned HW = 16
) (
  input  logic signed [HW-1:0]   mul_x,
  input  logic signed [HW-1:0]   mul_y,
  output logic signed [2*HW-1:0] mul_p
);
  localparam int unsigned PW = 2 * HW;
  logic signed [PW-1:0] x_ext;
  logic signed [PW-1:0] y_ext;

  always_comb begin
    x_ext = {{HW{mul_x[HW-1]}}, mul_x};
    y_ext = {{HW{mul_y[HW-1]}}, mul_y};
    mul_p = x_ext * y_ext;
  end
endmodule

// File: rtl/dmsa_lanes.sv
module dmsa_lanes #(
  parameter int unsigned HW = 16
) (
  input  logic [2*HW-1:0]        src_a,
  input  logic [2*HW-1:0]        src_b,
  input  logic                   swap_b,
  output logic signed [2*HW-1:0] prod_lo,
  output logic signed [2*HW-1:0] prod_hi
);
  localparam int unsigned WW = 2 * HW;
  localparam int unsigned NL = 2;

  logic [WW-1:0]        b_sel;
  logic signed [WW-1:0] prods [NL];

  always_comb begin
    if (swap_b) b_sel = {src_b[HW-1:0], src_b[WW-1:HW]};
    else        b_sel = src_b;
  end

  for (genvar g = 0; g < NL; g++) begin : g_lane
    dmsa_hmul #(.HW(HW)) u_mul (
      .mul_x (src_a[g*HW +: HW]),
      .mul_y (b_sel[g*HW +: HW]),
      .mul_p (prods[g])
    );
  end

  assign prod_lo = prods[0];
  assign prod_hi = prods[1];
endmodule

// File: rtl/dmsa_accum.sv
module dmsa_accum #(
  parameter int unsigned WW = 32
) (
  input  logic                 long_mode,
  input  logic signed [WW-1:0] prod_lo,
  input  logic signed [WW-1:0] prod_hi,
  input  logic [WW-1:0]        add_hi,
  input  logic [WW-1:0]        add_lo,
  output logic [WW-1:0]        sum_hi,
  output logic [WW-1:0]        sum_lo,
  output logic                 sum_ovf
);
  localparam int unsigned DW = WW + 1;
  localparam int unsigned LW = 2 * WW;

  logic [DW-1:0] diff_wide;
  logic [WW-1:0] diff;
  logic [WW-1:0] short_sum;
  logic [LW-1:0] long_sum;
  logic          short_ovf;

  always_comb begin
    diff_wide = {prod_lo[WW-1], prod_lo} - {prod_hi[WW-1], prod_hi};
    diff      = diff_wide[WW-1:0];
    short_sum = diff + add_lo;
    short_ovf = (diff[WW-1] == add_lo[WW-1]) && (short_sum[WW-1] != diff[WW-1]);
    long_sum  = {{WW{diff[WW-1]}}, diff} + {add_hi, add_lo};
    if (long_mode) begin
      sum_hi  = long_sum[LW-1:WW];
      sum_lo  = long_sum[WW-1:0];
      sum_ovf = 1'b0;
    end else begin
      sum_hi  = '0;
      sum_lo  = short_sum;
      sum_ovf = short_ovf;
    end
  end

  always_comb begin
    AST_DIFF_FITS: assert (diff_wide[DW-1] == diff_wide[WW-1]); // R4
  end
endmodule

// File: rtl/dual_msub_acc.sv
module dual_msub_acc
  import dmsa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              long_sel,
  input  logic              xchg_b,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic [WORD_W-1:0] acc_hi,
  input  logic [WORD_W-1:0] acc_lo,
  input  logic              q_clear,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_hi,
  output logic [WORD_W-1:0] res_lo,
  output logic              q_flag
);
  logic signed [WORD_W-1:0] p_lo;
  logic signed [WORD_W-1:0] p_hi;
  logic [WORD_W-1:0]        s_hi;
  logic [WORD_W-1:0]        s_lo;
  logic                     s_ovf;

  dword_t res_q, res_d;
  logic   vld_q, vld_d;
  logic   sat_q, sat_d;
  logic   res_en;

  dmsa_lanes #(.HW(HALF_W)) u_lanes (
    .src_a   (op_a),
    .src_b   (op_b),
    .swap_b  (xchg_b),
    .prod_lo (p_lo),
    .prod_hi (p_hi)
  );

  dmsa_accum #(.WW(WORD_W)) u_accum (
    .long_mode (long_sel),
    .prod_lo   (p_lo),
    .prod_hi   (p_hi),
    .add_hi    (acc_hi),
    .add_lo    (acc_lo),
    .sum_hi    (s_hi),
    .sum_lo    (s_lo),
    .sum_ovf   (s_ovf)
  );

  always_comb begin
    res_en   = in_valid;
    vld_d    = in_valid;
    res_d.hi = s_hi;
    res_d.lo = s_lo;
    sat_d    = (sat_q & ~q_clear) | (in_valid & s_ovf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      sat_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      sat_q <= sat_d;
      if (res_en) res_q <= res_d;
    end
  end

  assign res_valid = vld_q;
  assign res_hi    = res_q.hi;
  assign res_lo    = res_q.lo;
  assign q_flag    = sat_q;

  AST_Q_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (q_flag && !q_clear) |=> q_flag); // R6
  AST_LONG_NO_Q: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && long_sel && q_clear) |=> !q_flag); // R7
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid); // R8
  AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid); // R8
  AST_HOLD_RES: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(res_lo) && $stable(res_hi))); // R9
  AST_SHORT_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !long_sel) |=> (res_hi == '0)); // R3
endmodule

// File: tb/sim_dual_msub_acc.sv
module sim_dual_msub_acc;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, long_sel, xchg_b, q_clear;
  logic [31:0] op_a, op_b, acc_hi, acc_lo;
  logic        res_valid, q_flag;
  logic [31:0] res_hi, res_lo;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit mq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_msub_acc u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .long_sel(long_sel),
    .xchg_b(xchg_b), .op_a(op_a), .op_b(op_b), .acc_hi(acc_hi),
    .acc_lo(acc_lo), .q_clear(q_clear), .res_valid(res_valid),
    .res_hi(res_hi), .res_lo(res_lo), .q_flag(q_flag)
  );

  function automatic longint ref_diff(logic [31:0] a, logic [31:0] b, logic x);
    logic [31:0] bs;
    longint pl, ph;
    bs = x ? {b[15:0], b[31:16]} : b;
    pl = longint'($signed(a[15:0])) * longint'($signed(bs[15:0]));
    ph = longint'($signed(a[31:16])) * longint'($signed(bs[31:16]));
    return pl - ph;
  endfunction

  function automatic logic [63:0] ref_res(logic [31:0] a, logic [31:0] b, logic x,
                                          logic lm, logic [31:0] ah, logic [31:0] al);
    longint d, s;
    d = ref_diff(a, b, x);
    if (lm) return 64'(d) + {ah, al};
    s = d + longint'($signed(al));
    return {32'h0, s[31:0]};
  endfunction

  function automatic logic ref_ovf(logic [31:0] a, logic [31:0] b, logic x,
                                   logic lm, logic [31:0] al);
    longint s;
    if (lm) return 1'b0;
    s = ref_diff(a, b, x) + longint'($signed(al));
    return (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(string req, logic [31:0] a, logic [31:0] b, logic x,
                        logic lm, logic [31:0] ah, logic [31:0] al, logic clr);
    logic [63:0] e;
    e = ref_res(a, b, x, lm, ah, al);
    op_a = a; op_b = b; xchg_b = x; long_sel = lm;
    acc_hi = ah; acc_lo = al; q_clear = clr; in_valid = 1'b1;
    mq = (mq & ~clr) | ref_ovf(a, b, x, lm, al);
    @(negedge clk);
    in_valid = 1'b0; q_clear = 1'b0;
    check({req, " result"}, {res_hi, res_lo}, e);
    check({req, " valid"}, 64'(res_valid), 64'd1);
    check({req, " qflag"}, 64'(q_flag), 64'(mq));
  endtask

  task automatic idle(string req, logic clr);
    logic [63:0] held;
    held = {res_hi, res_lo};
    q_clear = clr; in_valid = 1'b0;
    op_a = $urandom; op_b = $urandom; acc_lo = $urandom; acc_hi = $urandom;
    mq = mq & ~clr;
    @(negedge clk);
    q_clear = 1'b0;
    check({req, " held"}, {res_hi, res_lo}, held);
    check({req, " valid low"}, 64'(res_valid), 64'd0);
    check({req, " qflag"}, 64'(q_flag), 64'(mq));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; in_valid = 0; long_sel = 0; xchg_b = 0; q_clear = 0;
    op_a = 0; op_b = 0; acc_hi = 0; acc_lo = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 reset res", {res_hi, res_lo}, 64'h0);
    check("R10 reset valid", 64'(res_valid), 64'd0);
    check("R10 reset q", 64'(q_flag), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 straight pairing: 3*5 - 2*7 + 100 = 101
    run_op("R1", 32'h0002_0003, 32'h0007_0005, 0, 0, 32'h0, 32'd100, 0);
    // R2 exchanged pairing: 3*7 - 2*5 = 11
    run_op("R2", 32'h0002_0003, 32'h0007_0005, 1, 0, 32'h0, 32'd0, 0);
    // R3 acc_hi has no effect in 32-bit mode, negative halfwords
    run_op("R3", 32'hFFFE_0004, 32'h0003_FFF9, 0, 0, 32'hDEAD_BEEF, 32'd7, 0);
    // R4 extreme difference, no overflow
    run_op("R4", 32'h8000_8000, 32'h7FFF_8000, 0, 0, 32'h0, 32'h0, 0);
    check("R4 value", 64'(res_lo), 64'd2147450880);
    // R5 positive overflow, wrapped sum delivered
    run_op("R5 pos", 32'h8000_8000, 32'h7FFF_8000, 0, 0, 32'h0, 32'h0001_0000, 0);
    check("R5 flag set", 64'(q_flag), 64'd1);
    // R6 sticky across a clean op and idle
    run_op("R6 sticky", 32'h0001_0001, 32'h0001_0001, 0, 0, 32'h0, 32'h0, 0);
    idle("R9 idle", 0);
    idle("R6 clear", 1);
    check("R6 cleared", 64'(q_flag), 64'd0);
    // R5 negative overflow: diff=-1, acc=min
    run_op("R5 neg", 32'h0000_0001, 32'h0000_FFFF, 0, 0, 32'h0, 32'h8000_0000, 0);
    check("R5 neg flag", 64'(q_flag), 64'd1);
    // R6 clear and new overflow same cycle: set wins
    run_op("R6 clr+ovf", 32'h0000_0001, 32'h0000_FFFF, 0, 0, 32'h0, 32'h8000_0000, 1);
    check("R6 set wins", 64'(q_flag), 64'd1);
    // R7 long mode: overflow-sized values wrap, no Q change; clear in same op
    run_op("R7 clr", 32'h8000_8000, 32'h7FFF_8000, 0, 1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1);
    check("R7 no q", 64'(q_flag), 64'd0);
    run_op("R7 neg", 32'h0000_0001, 32'h0000_FFFF, 1, 1, 32'h0, 32'h0, 0);
    run_op("R7 sext", 32'h0001_0000, 32'h0001_0000, 0, 1, 32'h0000_0001, 32'h0, 0);
    idle("R9 idle2", 0);

    // R8 back-to-back and mixed random traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb, rh, rl;
      ra = $urandom; rb = $urandom; rh = $urandom; rl = $urandom;
      if ((i % 7) == 0) rl = {1'b0, {31{1'b1}}} ^ ($urandom & 32'hFF);
      if ((i % 5) == 0) idle("R9 rand", ($urandom % 4) == 0);
      run_op("R8 rand", ra, rb, 1'($urandom), 1'($urandom), rh, rl, ($urandom % 6) == 0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule